// File: doc/BRIEF.md
# Block Acquisition Sequencer with Status Word

This controller runs one block-based acquisition at a time for a host processor. The host writes a command word on the local data bus. The word arms the controller, picks a two-bit measurement mode, and carries a five-bit select field that is passed straight on to the downstream filtering hardware.

Once the controller is armed, a start pulse enables sample acquisition. The sample counter's terminal output is registered once more, and that registered block-full signal ends the run. At the end of a run the controller raises a block-ready interrupt. The interrupt stays high until the host acknowledges it.

The host can read an 8-bit status word through a read strobe. The word holds a sticky overrun flag, which reports that output data could not be drained in time, together with the sequencer state and the command fields.

Top module: `meas_seq_ctrl`

## Requirements
- R1: After reset, the sequencer is idle, `acq_en` and `blk_ready` are low, the overrun flag is clear, and a status read returns 0x00.
- R2: A cycle with `cmd_wr` high stores `data_in`. The fields are: bit 0 is the arm bit, bits 2:1 are the mode, and bits 7:3 are the select field. From the next cycle on, `lo_sel` shows bits 7:3.
- R3: While the stored arm bit is 1, an idle sequencer becomes armed on the next clock edge. An armed sequencer whose arm bit reads 0 returns to idle.
- R4: A `start` seen while armed with the arm bit set puts the sequencer in the running state on the next edge. `acq_en` is high exactly while running. A `start` seen while idle has no effect.
- R5: `cnt_term` passes through one register stage before the sequencer uses it. A `cnt_term` high at edge k, seen while running, makes the sequencer done at edge k+1. `cnt_term` has no effect outside the running state. A command write during a run does not stop the run.
- R6: `blk_ready` is high exactly while the sequencer is done, and it holds until `irq_ack`. The sequencer leaves the done state for idle on the edge that samples `irq_ack`. A `start` seen while done has no effect.
- R7: `data_out` is 0 whenever `stat_rd` is low. While `stat_rd` is high, `data_out` shows the status word: bit 0 is the overrun flag, bits 2:1 are the state (idle 0, armed 1, running 2, done 3), bits 4:3 are the mode, bit 5 is the arm bit, bit 6 is `blk_ready`, and bit 7 is `acq_en`.
- R8: A cycle with `overrun` high sets the overrun flag. The flag then stays set with no further overrun.
- R9: A cycle with `stat_rd` high clears the overrun flag on the following edge, unless `overrun` is high in that same cycle. In that case the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| data_in | input | 8 | Local data bus, write side |
| start | input | 1 | Measurement start request |
| cnt_term | input | 1 | Sample counter terminal output |
| overrun | input | 1 | Output drain too slow indication |
| stat_rd | input | 1 | Status read strobe |
| irq_ack | input | 1 | Host acknowledge of block-ready |
| data_out | output | 8 | Local data bus, read side (zero when not read) |
| acq_en | output | 1 | Sample acquisition enable |
| blk_ready | output | 1 | Block-ready interrupt, level held |
| lo_sel | output | 5 | Select field from the command word |

## Verification
The sequence table runs two complete runs and checks `acq_en` and `blk_ready` after every edge. Along the way it applies a start while idle and a start while done, sends a terminal pulse while armed, and writes a disarming command in the middle of a run. Together these separate a correct sequencer from one that reacts to inputs in the wrong state or that misses the extra resync cycle. Directed reads then check the status packing under a non-zero mode and arm bit, and confirm that the bus stays zero without the strobe. Three overrun patterns follow: a single pulse before a read, a read with no overrun, and overrun held through the read. These show whether the flag is sticky, whether the read clears it, and whether a set on the same cycle wins over the read-clear.

// File: rtl/meas_seq_pkg.sv
package meas_seq_pkg;

  localparam int STAT_W = 8;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  // Status word layout: {acq, ready, arm, mode, state, overrun flag}
  function automatic logic [STAT_W-1:0] pack_status(
    input logic              nrt,
    input seq_state_e        st,
    input logic [MODE_W-1:0] mode,
    input logic              arm
  );
    logic [STAT_W-1:0] w;
    w    = '0;
    w[0] = nrt;
    w[2:1] = st;
    w[4:3] = mode;
    w[5] = arm;
    w[6] = (st == ST_DONE);
    w[7] = (st == ST_RUN);
    return w;
  endfunction

endpackage

// File: rtl/meas_cmd_reg.sv
module meas_cmd_reg
  import meas_seq_pkg::*;
#(
  parameter int DATA_W = STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  output logic              arm,
  output logic [MODE_W-1:0] mode,
  output logic [DATA_W-MODE_W-2:0] sel
);
  localparam int SEL_LO = MODE_W + 1;

  logic [DATA_W-1:0] cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cmd_q <= '0;
    else if (wr)  cmd_q <= din;
  end

  assign arm  = cmd_q[0];
  assign mode = cmd_q[MODE_W:1];
  assign sel  = cmd_q[DATA_W-1:SEL_LO];

  // R2
  cmd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (sel == $past(din[DATA_W-1:SEL_LO])) && (arm == $past(din[0])));

endmodule

// File: rtl/meas_term_sync.sv
module meas_term_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) pipe_q[0] <= 1'b0;
          else        pipe_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) pipe_q[g] <= 1'b0;
          else        pipe_q[g] <= pipe_q[g-1];
        end
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/meas_seq_fsm.sv
module meas_seq_fsm
  import meas_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       start,
  input  logic       blk_full,
  input  logic       irq_ack,
  output seq_state_e state,
  output logic       acq_en,
  output logic       blk_ready
);
  seq_state_e state_q, state_d;

  // named internal events for checking
  logic go_run, run_end, ack_take;
  assign go_run   = (state_q == ST_ARMED) && arm && start;
  assign run_end  = (state_q == ST_RUN) && blk_full;
  assign ack_take = (state_q == ST_DONE) && irq_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (arm)      state_d = ST_ARMED;
      ST_ARMED: if (!arm)     state_d = ST_IDLE;
                else if (start) state_d = ST_RUN;
      ST_RUN:   if (blk_full) state_d = ST_DONE;
      ST_DONE:  if (irq_ack)  state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state     = state_q;
  assign acq_en    = (state_q == ST_RUN);
  assign blk_ready = (state_q == ST_DONE);

  // R4
  start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_run |=> acq_en);
  // R5
  blk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_end |=> blk_ready);
  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_ready && !irq_ack) |=> blk_ready);
  // R6
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (state == ST_IDLE));
  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ready |=> !acq_en);
  // R4
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acq_en && blk_ready));

endmodule

// File: rtl/meas_status_reg.sv
module meas_status_reg
  import meas_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              overrun,
  input  seq_state_e        state,
  input  logic [MODE_W-1:0] mode,
  input  logic              arm,
  output logic [STAT_W-1:0] dout
);
  logic nrt_q, nrt_d;

  // set dominates the read-clear
  assign nrt_d = overrun | (nrt_q & ~rd);

  always_ff @(posedge clk) begin
    if (!rst_n) nrt_q <= 1'b0;
    else        nrt_q <= nrt_d;
  end

  assign dout = rd ? pack_status(nrt_q, state, mode, arm) : '0;

  // R8
  nrt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> nrt_q);
  // R8
  nrt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nrt_q && !rd) |=> nrt_q);
  // R9
  nrt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !overrun) |=> !nrt_q);
  // R7
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (dout == '0));

endmodule

// File: rtl/meas_seq_ctrl.sv
module meas_seq_ctrl
  import meas_seq_pkg::*;
#(
  parameter int DATA_W      = STAT_W,
  parameter int SYNC_STAGES = 1,
  localparam int SEL_W      = DATA_W - MODE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              start,
  input  logic              cnt_term,
  input  logic              overrun,
  input  logic              stat_rd,
  input  logic              irq_ack,
  output logic [DATA_W-1:0] data_out,
  output logic              acq_en,
  output logic              blk_ready,
  output logic [SEL_W-1:0]  lo_sel
);
  logic              arm;
  logic [MODE_W-1:0] mode;
  logic              blk_full;
  seq_state_e        state;

  meas_cmd_reg #(.DATA_W(DATA_W)) i_cmd (
    .clk(clk), .rst_n(rst_n), .wr(cmd_wr), .din(data_in),
    .arm(arm), .mode(mode), .sel(lo_sel)
  );

  meas_term_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(cnt_term), .q(blk_full)
  );

  meas_seq_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .arm(arm), .start(start),
    .blk_full(blk_full), .irq_ack(irq_ack), .state(state),
    .acq_en(acq_en), .blk_ready(blk_ready)
  );

  meas_status_reg i_stat (
    .clk(clk), .rst_n(rst_n), .rd(stat_rd), .overrun(overrun),
    .state(state), .mode(mode), .arm(arm), .dout(data_out)
  );

  // R5
  term_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acq_en && !blk_ready) |=> !blk_ready);

endmodule

// File: tb/test_meas_seq_ctrl.sv
module test_meas_seq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, cmd_wr, start, cnt_term, overrun, stat_rd, irq_ack;
  logic [7:0] data_in, data_out;
  logic       acq_en, blk_ready;
  logic [4:0] lo_sel;

  int n_checks = 0;
  int n_errs   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  meas_seq_ctrl i_meas_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_in(data_in),
    .start(start), .cnt_term(cnt_term), .overrun(overrun),
    .stat_rd(stat_rd), .irq_ack(irq_ack), .data_out(data_out),
    .acq_en(acq_en), .blk_ready(blk_ready), .lo_sel(lo_sel)
  );

  // {wr, data[7:0], start, term, ack, exp_acq, exp_rdy}
  localparam logic [13:0] VEC [19] = '{
    {1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 arm write
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 armed
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 start
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 term sampled
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 done after resync
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 start ignored
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 held
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R6 ack
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 re-armed
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 term while armed
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R4
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 stale term ignored
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 disarm mid-run
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 stays idle
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}  // R4 start in idle
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // status word restated from R7: state code 0..3, ready in done, acq in running
  function automatic logic [7:0] exp_status(input logic nrt, input logic [1:0] st,
                                            input logic [1:0] md, input logic a);
    return {st == 2'd2, st == 2'd3, a, md, st, nrt};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one-cycle read; returns bus value sampled mid-cycle
  task automatic read_status(output logic [7:0] v);
    stat_rd = 1'b1;
    #1 v = data_out;
    step();
    stat_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_errs++;
    n_checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 0; cmd_wr = 0; data_in = 0; start = 0; cnt_term = 0;
    overrun = 0; stat_rd = 0; irq_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 acq_en", {7'd0, acq_en}, 8'd0);
    check("R1 blk_ready", {7'd0, blk_ready}, 8'd0);
    read_status(v);
    check("R1 status", v, 8'h00);

    // table walk
    foreach (VEC[i]) begin
      cmd_wr   = VEC[i][13];
      data_in  = VEC[i][12:5];
      start    = VEC[i][4];
      cnt_term = VEC[i][3];
      irq_ack  = VEC[i][2];
      step();
      cmd_wr = 0; start = 0; cnt_term = 0; irq_ack = 0;
      check($sformatf("R4/R5/R6 acq_en vec%0d", i), {7'd0, acq_en}, {7'd0, VEC[i][1]});
      check($sformatf("R6 blk_ready vec%0d", i), {7'd0, blk_ready}, {7'd0, VEC[i][0]});
    end

    // R2 select field and status packing
    cmd_wr = 1; data_in = 8'hA8;
    step();
    cmd_wr = 0;
    check("R2 lo_sel", {3'd0, lo_sel}, 8'h15);
    cmd_wr = 1; data_in = 8'h05;
    step();
    cmd_wr = 0;
    step();
    read_status(v);
    check("R7 status armed mode2", v, exp_status(1'b0, 2'd1, 2'd2, 1'b1));
    #1 check("R7 bus idle", data_out, 8'h00);

    // R8 single overrun pulse, sticky
    overrun = 1;
    step();
    overrun = 0;
    step();
    read_status(v);
    check("R8 flag set", {7'd0, v[0]}, 8'd1);
    // R9 read cleared it
    read_status(v);
    check("R9 flag cleared", {7'd0, v[0]}, 8'd0);
    // R9 set wins over read-clear
    overrun = 1;
    step();
    read_status(v);
    overrun = 0;
    read_status(v);
    check("R9 set beats clear", {7'd0, v[0]}, 8'd1);
    read_status(v);
    check("R9 cleared after", {7'd0, v[0]}, 8'd0);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule